// File: doc/BRIEF.md
# Justified-Buffer SPI Target

This block is the receiving side of an SPI link. It is built around a shift register of fixed width, 16 bits by default. Only a programmable number of clocks, from 1 to 16, is exchanged per character. Software pushes transmit words left-justified, so the first bit on the wire is the word's most significant bit. It pops received words right-justified: the newest bits sit at the bottom, and the upper bits still hold what the register contained before. Those upper bits are never masked.

The serial pins SCLK, SS and MOSI are sampled by the system clock through two-flop synchronizers, and the link runs in SPI mode 0. Each direction can use either a 4-entry queue or a single buffer, picked by one configuration input. When software has queued no new word at a character boundary, the register keeps shifting out whatever it already holds. The output-enable for MISO follows a talk control and the select line.

Top module: `spis_core`

## Requirements
- R1: After reset, tx_empty and rx_empty are 1, tx_full, rx_full and rx_ovf are 0, rx_rdata is 0 and miso_oe is 0.
- R2: While ss_n is low, each SCLK rising edge shifts the mosi bit into bit 0 of the shift register, and miso takes the next bit after each falling edge (mode 0). A character is exactly cfg_char_len+1 rising edges long (field 0..15 gives 1..16 bits).
- R3: Transmit words are left-justified: a character of n bits sends bits 15 down to 16-n of the loaded word, bit 15 first. The first queued word is loaded when ss_n falls, and the next one at each character end.
- R4: A completed character is queued as the full 16-bit register: (loaded word << n) | received bits, truncated to 16 bits, so stale upper bits stay visible.
- R5: A rising ss_n in the middle of a character queues the shift register as it stands and restarts the bit count.
- R6: If no transmit word is queued at a character end, nothing is loaded, and the next character re-sends the register's residual bits.
- R7: rx_rdata reads all zeros whenever the receive queue is empty.
- R8: With cfg_fifo_en = 0 each direction holds one word. tx_full rises after one write, and a write while full is dropped.
- R9: With cfg_fifo_en = 1 each direction holds 4 words, delivered in write and arrival order.
- R10: A character completing while the receive side is full is dropped and sets rx_ovf, which stays set until reset.
- R11: miso_oe is 1 only while cfg_talk is 1 and the synchronized ss_n is low; with cfg_talk = 0 the output is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the master |
| ss_n | input | 1 | Active-low select |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for the miso pad |
| cfg_fifo_en | input | 1 | 1: 4-deep queues, 0: single buffers |
| cfg_talk | input | 1 | Enables driving miso |
| cfg_char_len | input | 4 | Character length minus one |
| tx_wr | input | 1 | Write strobe for tx_wdata |
| tx_wdata | input | 16 | Left-justified transmit word |
| tx_full | output | 1 | Transmit side full |
| tx_empty | output | 1 | Transmit side empty |
| rx_rd | input | 1 | Pops the head received word |
| rx_rdata | output | 16 | Head received word, right-justified |
| rx_full | output | 1 | Receive side full |
| rx_empty | output | 1 | Receive side empty |
| rx_ovf | output | 1 | Sticky receive overflow |

## Verification
The properties assume that SCLK and SS change slowly compared with clk, so that every serial edge survives the synchronizers as a separate event. They also assume that ss_n is never toggled in the same system cycle as an SCLK edge, and that cfg_fifo_en changes only while both queues are empty. The stimulus keeps each SCLK half period at six or more system cycles and moves ss_n only with SCLK low and settled. It switches the queue mode only after draining both queues.

// File: rtl/spis_pkg.sv
package spis_pkg;
  localparam int SR_W_DEF   = 16;
  localparam int DEPTH_DEF  = 4;
  localparam int STAGES_DEF = 2;

  typedef struct packed {
    logic sclk;
    logic ss_n;
    logic mosi;
  } pins_t;
endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] st_d;
    if (g == 0) begin : g_first
      assign st_d = d;
    end else begin : g_next
      assign st_d = st_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q[g] <= RST_VAL;
      else        st_q[g] <= st_d;
    end
  end

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/spis_fifo.sv
module spis_fifo #(
  parameter int W = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         single,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  mem_q [DEPTH];
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = single ? !empty : (cnt_q == CW'(DEPTH));
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign dout    = mem_q[rp_q];

  always_comb begin
    wp_d  = do_push ? ptr_inc(wp_q) : wp_q;
    rp_d  = do_pop  ? ptr_inc(rp_q) : rp_q;
    cnt_d = cnt_q;
    if (do_push && !do_pop)      cnt_d = cnt_q + CW'(1);
    else if (do_pop && !do_push) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic wen;
    assign wen = do_push && (wp_q == PW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem_q[g] <= '0;
      else if (wen) mem_q[g] <= din;
    end
  end
endmodule

// File: rtl/spis_core.sv
module spis_core #(
  parameter int SR_W = spis_pkg::SR_W_DEF,
  parameter int DEPTH = spis_pkg::DEPTH_DEF,
  parameter int SYNC_STAGES = spis_pkg::STAGES_DEF,
  localparam int CL_W = $clog2(SR_W),
  localparam int CNT_W = $clog2(SR_W + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sclk,
  input  logic            ss_n,
  input  logic            mosi,
  output logic            miso,
  output logic            miso_oe,
  input  logic            cfg_fifo_en,
  input  logic            cfg_talk,
  input  logic [CL_W-1:0] cfg_char_len,
  input  logic            tx_wr,
  input  logic [SR_W-1:0] tx_wdata,
  output logic            tx_full,
  output logic            tx_empty,
  input  logic            rx_rd,
  output logic [SR_W-1:0] rx_rdata,
  output logic            rx_full,
  output logic            rx_empty,
  output logic            rx_ovf
);
  import spis_pkg::*;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  // pin synchronizers and edge detection
  pins_t pins_raw, pins_s;
  logic  sclk_d_q, ss_d_q;
  assign pins_raw = '{sclk: sclk, ss_n: ss_n, mosi: mosi};

  spis_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .d(pins_raw), .q(pins_s)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      sclk_d_q <= 1'b0;
      ss_d_q   <= 1'b1;
    end else begin
      sclk_d_q <= pins_s.sclk;
      ss_d_q   <= pins_s.ss_n;
    end
  end

  logic sel, sclk_rise, sclk_fall, ss_fall, ss_rise;
  assign sel       = ~pins_s.ss_n;
  assign sclk_rise = pins_s.sclk & ~sclk_d_q;
  assign sclk_fall = ~pins_s.sclk & sclk_d_q;
  assign ss_fall   = ~pins_s.ss_n & ss_d_q;
  assign ss_rise   = pins_s.ss_n & ~ss_d_q;

  // queues
  logic            tx_pop, rx_push;
  logic [SR_W-1:0] tx_head, rx_head, rx_din;

  spis_fifo #(.W(SR_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_core_n), .single(~cfg_fifo_en),
    .push(tx_wr), .din(tx_wdata), .pop(tx_pop),
    .dout(tx_head), .empty(tx_empty), .full(tx_full)
  );

  spis_fifo #(.W(SR_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_core_n), .single(~cfg_fifo_en),
    .push(rx_push), .din(rx_din), .pop(rx_rd),
    .dout(rx_head), .empty(rx_empty), .full(rx_full)
  );

  // shift engine
  logic [SR_W-1:0]  sr_q, sr_d, sr_shift;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, char_len;
  logic             loaded_q, loaded_d, miso_q, miso_d, ovf_q, ovf_d;

  assign sr_shift = {sr_q[SR_W-2:0], pins_s.mosi};
  assign cnt_inc  = cnt_q + CNT_W'(1);
  assign char_len = CNT_W'(cfg_char_len) + CNT_W'(1);

  always_comb begin
    sr_d     = sr_q;
    cnt_d    = cnt_q;
    loaded_d = loaded_q;
    miso_d   = miso_q;
    tx_pop   = 1'b0;
    rx_push  = 1'b0;
    rx_din   = sr_q;
    if (ss_fall) begin
      cnt_d = '0;
      if (!loaded_q && !tx_empty) begin
        sr_d     = tx_head;
        tx_pop   = 1'b1;
        loaded_d = 1'b1;
        miso_d   = tx_head[SR_W-1];
      end else begin
        miso_d   = sr_q[SR_W-1];
      end
    end else if (ss_rise) begin
      cnt_d = '0;
      if (cnt_q != '0) rx_push = 1'b1;
    end else if (sel && sclk_rise) begin
      loaded_d = 1'b0;
      if (cnt_inc == char_len) begin
        cnt_d   = '0;
        rx_push = 1'b1;
        rx_din  = sr_shift;
        if (!tx_empty) begin
          sr_d     = tx_head;
          tx_pop   = 1'b1;
          loaded_d = 1'b1;
        end else begin
          sr_d     = sr_shift;
        end
      end else begin
        cnt_d = cnt_inc;
        sr_d  = sr_shift;
      end
    end else if (sel && sclk_fall) begin
      miso_d = sr_q[SR_W-1];
    end
    ovf_d = ovf_q | (rx_push & rx_full);
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      sr_q     <= '0;
      cnt_q    <= '0;
      loaded_q <= 1'b0;
      miso_q   <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      sr_q     <= sr_d;
      cnt_q    <= cnt_d;
      loaded_q <= loaded_d;
      miso_q   <= miso_d;
      ovf_q    <= ovf_d;
    end
  end

  assign miso     = miso_q;
  assign miso_oe  = cfg_talk & sel;
  assign rx_ovf   = ovf_q;
  assign rx_rdata = rx_empty ? '0 : rx_head;
endmodule

// File: rtl/spis_core_chk.sv
module spis_core_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ss_n,
  input logic         cfg_talk,
  input logic         miso_oe,
  input logic         rx_ovf,
  input logic         rx_full,
  input logic         rx_empty,
  input logic [W-1:0] rx_rdata,
  input logic         tx_full,
  input logic         tx_empty
);
  p_empty_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty |-> (rx_rdata == '0));

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf |=> rx_ovf);

  p_ovf_needs_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ovf) |-> $past(rx_full));

  p_tx_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_full && tx_empty));

  p_rx_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_full && rx_empty));

  p_talk_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_talk |-> !miso_oe);

  p_idle_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_n && $past(ss_n) && $past(ss_n, 2)) |-> !miso_oe);
endmodule

bind spis_core spis_core_chk #(.W(SR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .cfg_talk(cfg_talk),
  .miso_oe(miso_oe), .rx_ovf(rx_ovf), .rx_full(rx_full),
  .rx_empty(rx_empty), .rx_rdata(rx_rdata), .tx_full(tx_full),
  .tx_empty(tx_empty)
);

// File: tb/tb_spis_core.sv
module tb_spis_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, ss_n = 1'b1, mosi = 1'b0;
  logic        miso, miso_oe;
  logic        cfg_fifo_en = 1'b0, cfg_talk = 1'b1;
  logic [3:0]  cfg_char_len = 4'd7;
  logic        tx_wr = 1'b0, rx_rd = 1'b0;
  logic [15:0] tx_wdata = '0, rx_rdata;
  logic        tx_full, tx_empty, rx_full, rx_empty, rx_ovf;
  int          checks = 0, errors = 0;

  always #4 clk = ~clk;

  spis_core dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .ss_n(ss_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .cfg_fifo_en(cfg_fifo_en),
    .cfg_talk(cfg_talk), .cfg_char_len(cfg_char_len), .tx_wr(tx_wr),
    .tx_wdata(tx_wdata), .tx_full(tx_full), .tx_empty(tx_empty),
    .rx_rd(rx_rd), .rx_rdata(rx_rdata), .rx_full(rx_full),
    .rx_empty(rx_empty), .rx_ovf(rx_ovf)
  );

  // {len-1[4], tx word[16], mosi bits[16], expected miso bits[16], expected rx[16]}
  localparam logic [67:0] VEC [5] = '{
    {4'd7,  16'hA53C, 16'h005A, 16'h00A5, 16'h3C5A},
    {4'd15, 16'h1234, 16'hBEEF, 16'h1234, 16'hBEEF},
    {4'd3,  16'hC7F0, 16'h0009, 16'h000C, 16'h7F09},
    {4'd0,  16'h8001, 16'h0000, 16'h0001, 16'h0002},
    {4'd11, 16'h0ABC, 16'h0123, 16'h00AB, 16'hC123}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_tx(input logic [15:0] w);
    @(negedge clk); tx_wr = 1'b1; tx_wdata = w;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic pop_rx;
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
    wait_clk(2);
  endtask

  // one select period carrying n bits, MSB of the n-bit field first
  task automatic frame(input int n, input logic [31:0] mbits, output logic [31:0] got);
    got = '0;
    @(negedge clk); ss_n = 1'b0;
    wait_clk(10);
    for (int i = 0; i < n; i++) begin
      mosi = mbits[n-1-i];
      wait_clk(4);
      sclk = 1'b1;
      got = {got[30:0], miso};
      wait_clk(6);
      sclk = 1'b0;
      wait_clk(6);
    end
    ss_n = 1'b1;
    wait_clk(10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] got;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(6);
    // R1 reset state
    chk("R1 tx_empty", tx_empty, 1);
    chk("R1 rx_empty", rx_empty, 1);
    chk("R1 flags", {tx_full, rx_full, rx_ovf, miso_oe}, 0);
    chk("R1 rx_rdata", rx_rdata, 0);

    // R2 R3 R4: single-buffer table walk
    for (int v = 0; v < 5; v++) begin
      cfg_char_len = VEC[v][67:64];
      write_tx(VEC[v][63:48]);
      frame(int'(VEC[v][67:64]) + 1, {16'h0, VEC[v][47:32]}, got);
      chk($sformatf("R2/R3 miso vec%0d", v), got, {16'h0, VEC[v][31:16]});
      chk($sformatf("R4 rx vec%0d", v), rx_rdata, {16'h0, VEC[v][15:0]});
      pop_rx();
      chk($sformatf("R7 drained vec%0d", v), {rx_empty, rx_rdata}, {1'b1, 16'h0});
    end

    // R8: single buffer, second write dropped
    cfg_char_len = 4'd15;
    write_tx(16'h1111);
    chk("R8 full after one", {tx_full, tx_empty}, 2'b10);
    write_tx(16'h2222);
    frame(16, 32'h0, got);
    chk("R8 second write dropped", got, 32'h1111);
    chk("R8 tx drained", tx_empty, 1);
    pop_rx();

    // R5: select rises after 3 of 8 bits
    cfg_char_len = 4'd7;
    write_tx(16'hFF00);
    frame(3, 32'h5, got);
    chk("R5 partial miso", got, 32'h7);
    chk("R5 partial latch", rx_rdata, 16'hF805);
    pop_rx();

    // R11 talk control
    cfg_talk = 1'b0;
    @(negedge clk); ss_n = 1'b0;
    wait_clk(6);
    chk("R11 talk off", miso_oe, 0);
    cfg_talk = 1'b1;
    wait_clk(1);
    chk("R11 talk on", miso_oe, 1);
    ss_n = 1'b1;
    wait_clk(6);
    chk("R11 deselected", miso_oe, 0);

    // R6: underflow, three 8-bit characters from one word
    cfg_fifo_en = 1'b1;
    write_tx(16'hA55A);
    frame(24, 32'h003C8100, got);
    chk("R6 residual resent", got, 32'h00A55A3C);
    chk("R6 rx char1", rx_rdata, 16'h5A3C); pop_rx();
    chk("R6 rx char2", rx_rdata, 16'h3C81); pop_rx();
    chk("R6 rx char3", rx_rdata, 16'h8100); pop_rx();

    // R9 R10: 4-deep ordering, dropped write, overflow
    cfg_char_len = 4'd15;
    write_tx(16'h1357); write_tx(16'h2468); write_tx(16'h9ABC); write_tx(16'hDEF0);
    chk("R9 tx full at four", tx_full, 1);
    write_tx(16'h5555);
    frame(16, 32'h0101, got); chk("R9 order w0", got, 32'h1357);
    frame(16, 32'h0202, got); chk("R9 order w1", got, 32'h2468);
    frame(16, 32'h0303, got); chk("R9 order w2", got, 32'h9ABC);
    frame(16, 32'h0404, got); chk("R9 order w3", got, 32'hDEF0);
    chk("R10 rx full", {rx_full, rx_ovf}, 2'b10);
    frame(16, 32'h0505, got);
    chk("R6 residual after drop", got, 32'h0404);
    chk("R10 overflow set", rx_ovf, 1);
    chk("R9 rx head m0", rx_rdata, 16'h0101); pop_rx();
    chk("R9 rx m1", rx_rdata, 16'h0202); pop_rx();
    chk("R9 rx m2", rx_rdata, 16'h0303); pop_rx();
    chk("R10 rx m3 kept, new dropped", rx_rdata, 16'h0404); pop_rx();
    chk("R7 empty zero", {rx_empty, rx_rdata}, {1'b1, 16'h0});
    chk("R10 sticky", rx_ovf, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule